// File: doc/BRIEF.md
# Speculative Execution Pipeline with Shadow-Tag Cancellation

This block is an in-order execution pipeline that never stalls while waiting to learn whether a speculative operation will fault. Each speculation point is an operation that might raise an exception, a branch whose direction is still unknown, or a point where an interrupt may be taken. At issue, such a point takes a free shadow ID. Every operation in flight carries a bit mask of the shadows it depends on. The operation that opens a shadow, and every operation issued after it while that shadow stays open, has that shadow's bit set.

Later, the surrounding control logic settles each shadow by ID. A resolve clears the bit everywhere, so dependent results can retire. A cancel drops, in the same cycle, every entry whose mask holds that bit, and then raises a one-cycle redirect so that the front end can restart from the right address. Exceptions, interrupts and mispredicted branches all use the same cancel path. An operation reaches the commit output only from the last stage, and only when its mask is empty. Until then it waits there, and operations behind it queue up. The datapath is a plain adder, with the sum formed at issue.

Top module: `shp_cancel_pipe`

## Requirements
- R1: An entry in the last stage commits (`commit_valid` high, `commit_data` = its sum) only when its mask is zero. Otherwise it stays there with its data unchanged, and younger entries queue behind it. Operations commit in issue order.
- R2: An issued operation's mask is the set of shadows open in that cycle, less any shadow resolved in that cycle, plus its own new shadow when `iss_spec` is high.
- R3: A speculative issue takes the lowest-numbered free shadow ID, shown on `iss_id`. When all `NUM_SH` IDs are in use, `iss_ready` is low for a speculative request but may be high for a plain one.
- R4: A resolve of an open ID clears that bit in every in-flight mask at the next edge. The ID can be allocated again from the next cycle.
- R5: A cancel of ID k removes every entry whose mask has bit k, including the operation that opened k, in the same cycle. None of them ever commits. ID k is freed.
- R6: When cancel and resolve name the same ID in the same cycle, the cancel wins and the resolve has no effect.
- R7: In the cycle after a cancel, `redirect_valid` is high for one cycle with `redirect_id` equal to the cancelled ID. At that point no entry holds that bit.
- R8: `iss_ready` is low in any cycle in which `cancel_valid` is high.
- R9: A synchronous active-high `rst` empties every stage, frees every ID and clears the redirect.
- R10: A plain operation issued into an empty pipeline commits exactly `DEPTH` cycles after its issue cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_spec | input | 1 | Issued operation opens a new shadow |
| iss_a | input | DATA_W | First operand |
| iss_b | input | DATA_W | Second operand |
| iss_ready | output | 1 | Issue accepted this cycle when high |
| iss_id | output | ID_W | Shadow ID a speculative issue receives |
| resolve_valid | input | 1 | Shadow settled as not faulting |
| resolve_id | input | ID_W | ID being resolved |
| cancel_valid | input | 1 | Shadow cancelled |
| cancel_id | input | ID_W | ID being cancelled |
| commit_valid | output | 1 | Result retires this cycle |
| commit_data | output | DATA_W | Retiring sum |
| redirect_valid | output | 1 | Restart request following a cancel |
| redirect_id | output | ID_W | Shadow whose cancel caused the redirect |

## Verification
A mask bit left stale after a resolve shows up at the ports as a result that never retires: `commit_valid` stays low for good, and the reference model flags it in the first cycle its retirement was due. A kill that is missed or lands on the wrong entry shows up as a dropped or extra commit, caught on the same clock. A wrong allocation or free list shows up at once on `iss_id` or `iss_ready`. A busy set that does not match the in-flight masks is also checked directly against the stage state on every edge.

// File: rtl/shp_pkg.sv
package shp_pkg;
   localparam int unsigned SHP_MAX_SHADOWS = 32;
   localparam int unsigned SHP_MIN_DEPTH   = 2;

   function automatic int unsigned shp_id_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/shp_alloc.sv
module shp_alloc
   import shp_pkg::*;
#(
   parameter int unsigned NUM_SH = 4,
   localparam int unsigned ID_W  = shp_id_width(NUM_SH)
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_SH-1:0] take_vec,
   input  logic [NUM_SH-1:0] rel_vec,
   output logic [NUM_SH-1:0] busy,
   output logic              any_free,
   output logic [ID_W-1:0]   free_id
);
   logic [NUM_SH-1:0] busy_q;

   always_ff @(posedge clk) begin
      if (rst) busy_q <= '0;
      else     busy_q <= (busy_q & ~rel_vec) | take_vec;
   end

   assign busy = busy_q;

   generate
      if (NUM_SH == 1) begin : g_single
         assign any_free = ~busy_q[0];
         assign free_id  = '0;
      end else begin : g_prio
         always_comb begin
            free_id  = '0;
            any_free = 1'b0;
            for (int j = NUM_SH - 1; j >= 0; j--) begin
               if (!busy_q[j]) begin
                  free_id  = ID_W'(j);
                  any_free = 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/shp_stage.sv
module shp_stage #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned NUM_SH = 4
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [NUM_SH-1:0] ld_mask,
   input  logic              vacate,
   input  logic [NUM_SH-1:0] kill_vec,
   input  logic [NUM_SH-1:0] res_vec,
   output logic              valid_o,
   output logic              live_o,
   output logic [NUM_SH-1:0] mask_o,
   output logic [DATA_W-1:0] data_o
);
   logic              vld_q;
   logic [NUM_SH-1:0] msk_q;
   logic [DATA_W-1:0] dat_q;

   assign live_o  = vld_q & ~|(msk_q & kill_vec);
   assign valid_o = vld_q;
   assign mask_o  = msk_q;
   assign data_o  = dat_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= 1'b0;
         msk_q <= '0;
         dat_q <= '0;
      end else if (load) begin
         vld_q <= 1'b1;
         msk_q <= ld_mask;
         dat_q <= ld_data;
      end else if (vacate) begin
         vld_q <= 1'b0;
      end else begin
         vld_q <= live_o;
         msk_q <= msk_q & ~res_vec;
      end
   end
endmodule

// File: rtl/shp_cancel_pipe.sv
module shp_cancel_pipe
   import shp_pkg::*;
#(
   parameter int unsigned NUM_SH = 4,
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned DATA_W = 16,
   localparam int unsigned ID_W  = shp_id_width(NUM_SH)
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              iss_valid,
   input  logic              iss_spec,
   input  logic [DATA_W-1:0] iss_a,
   input  logic [DATA_W-1:0] iss_b,
   output logic              iss_ready,
   output logic [ID_W-1:0]   iss_id,
   input  logic              resolve_valid,
   input  logic [ID_W-1:0]   resolve_id,
   input  logic              cancel_valid,
   input  logic [ID_W-1:0]   cancel_id,
   output logic              commit_valid,
   output logic [DATA_W-1:0] commit_data,
   output logic              redirect_valid,
   output logic [ID_W-1:0]   redirect_id
);
   generate
      if (NUM_SH < 1 || NUM_SH > SHP_MAX_SHADOWS) begin : g_bad_sh
         $error("shp_cancel_pipe: NUM_SH out of range");
      end
      if (DEPTH < SHP_MIN_DEPTH) begin : g_bad_depth
         $error("shp_cancel_pipe: DEPTH too small");
      end
      if (DATA_W < 1) begin : g_bad_w
         $error("shp_cancel_pipe: DATA_W must be positive");
      end
   endgenerate

   logic [NUM_SH-1:0] cancel_vec, res_vec, busy, new_bit, take_vec, iss_mask;
   logic              any_free, iss_fire, last_done;
   logic [ID_W-1:0]   free_id;
   logic [DEPTH-1:0]  stg_valid, live, free_nx, move;
   logic [DEPTH-1:0][NUM_SH-1:0] stg_mask;
   logic [DEPTH-1:0][DATA_W-1:0] stg_data;
   logic              redir_q;
   logic [ID_W-1:0]   redir_id_q;

   always_comb begin
      cancel_vec = '0;
      res_vec    = '0;
      if (cancel_valid) cancel_vec[cancel_id] = 1'b1;
      if (resolve_valid && !(cancel_valid && cancel_id == resolve_id))
         res_vec[resolve_id] = 1'b1;
   end

   // back-pressure chain: a slot frees when empty, killed or its entry leaves
   always_comb begin
      last_done        = live[DEPTH-1] & ~|stg_mask[DEPTH-1];
      free_nx[DEPTH-1] = ~live[DEPTH-1] | last_done;
      move[DEPTH-1]    = last_done;
      for (int i = DEPTH - 2; i >= 0; i--) begin
         move[i]    = live[i] & free_nx[i+1];
         free_nx[i] = ~live[i] | free_nx[i+1];
      end
   end

   always_comb begin
      new_bit = '0;
      if (iss_spec && any_free) new_bit[free_id] = 1'b1;
   end

   assign iss_ready = ~cancel_valid & free_nx[0] & (~iss_spec | any_free);
   assign iss_fire  = iss_valid & iss_ready;
   assign iss_id    = free_id;
   assign iss_mask  = (busy & ~res_vec) | new_bit;
   assign take_vec  = (iss_fire && iss_spec) ? new_bit : '0;

   shp_alloc #(.NUM_SH(NUM_SH)) u_alloc (
      .clk      (clk),
      .rst      (rst),
      .take_vec (take_vec),
      .rel_vec  (res_vec | cancel_vec),
      .busy     (busy),
      .any_free (any_free),
      .free_id  (free_id)
   );

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_stg
         logic              ld;
         logic [DATA_W-1:0] ld_data;
         logic [NUM_SH-1:0] ld_mask;
         if (g == 0) begin : g_head
            assign ld      = iss_fire;
            assign ld_data = iss_a + iss_b;
            assign ld_mask = iss_mask;
         end else begin : g_body
            assign ld      = move[g-1];
            assign ld_data = stg_data[g-1];
            assign ld_mask = stg_mask[g-1] & ~res_vec;
         end
         shp_stage #(.DATA_W(DATA_W), .NUM_SH(NUM_SH)) u_stage (
            .clk      (clk),
            .rst      (rst),
            .load     (ld),
            .ld_data  (ld_data),
            .ld_mask  (ld_mask),
            .vacate   (free_nx[g]),
            .kill_vec (cancel_vec),
            .res_vec  (res_vec),
            .valid_o  (stg_valid[g]),
            .live_o   (live[g]),
            .mask_o   (stg_mask[g]),
            .data_o   (stg_data[g])
         );
      end
   endgenerate

   assign commit_valid = last_done;
   assign commit_data  = stg_data[DEPTH-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         redir_q    <= 1'b0;
         redir_id_q <= '0;
      end else begin
         redir_q    <= cancel_valid;
         redir_id_q <= cancel_id;
      end
   end

   assign redirect_valid = redir_q;
   assign redirect_id    = redir_id_q;
endmodule

// File: rtl/shp_cancel_pipe_chk.sv
module shp_cancel_pipe_chk #(
   parameter int unsigned NUM_SH = 4,
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ID_W   = 2
)(
   input logic                         clk,
   input logic                         rst,
   input logic                         iss_spec,
   input logic                         iss_ready,
   input logic                         resolve_valid,
   input logic [ID_W-1:0]              resolve_id,
   input logic                         cancel_valid,
   input logic [ID_W-1:0]              cancel_id,
   input logic                         redirect_valid,
   input logic [ID_W-1:0]              redirect_id,
   input logic [NUM_SH-1:0]            busy,
   input logic [DEPTH-1:0]             stg_valid,
   input logic [DEPTH-1:0][NUM_SH-1:0] stg_mask,
   input logic [DEPTH-1:0][DATA_W-1:0] stg_data
);
   assert_reset_R9: assert property (@(posedge clk)
      rst |=> (busy == '0) && (stg_valid == '0) && !redirect_valid);

   assert_spec_stall_R3: assert property (@(posedge clk) disable iff (rst)
      (iss_spec && (&busy)) |-> !iss_ready);

   assert_cancel_blocks_R8: assert property (@(posedge clk) disable iff (rst)
      cancel_valid |-> !iss_ready);

   assert_redirect_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      cancel_valid |=> redirect_valid && (redirect_id == $past(cancel_id)));

   assert_last_holds_R1: assert property (@(posedge clk) disable iff (rst)
      (stg_valid[DEPTH-1] && (|stg_mask[DEPTH-1]) && !cancel_valid && !resolve_valid)
      |=> stg_valid[DEPTH-1] && $stable(stg_data[DEPTH-1]));

   generate
      for (genvar j = 0; j < NUM_SH; j++) begin : g_id
         assert_cancel_prio_R6: assert property (@(posedge clk) disable iff (rst)
            (cancel_valid && cancel_id == j && resolve_valid && resolve_id == j)
            |=> !busy[j]);
         for (genvar k = 0; k < DEPTH; k++) begin : g_st
            assert_mask_open_R2: assert property (@(posedge clk) disable iff (rst)
               stg_valid[k] |-> !(stg_mask[k][j] && !busy[j]));
            assert_kill_R5: assert property (@(posedge clk) disable iff (rst)
               (cancel_valid && cancel_id == j) |=> !(stg_valid[k] && stg_mask[k][j]));
            assert_release_R4: assert property (@(posedge clk) disable iff (rst)
               (resolve_valid && resolve_id == j && busy[j] &&
                !(cancel_valid && cancel_id == j))
               |=> !(stg_valid[k] && stg_mask[k][j]));
            assert_redirect_clean_R7: assert property (@(posedge clk) disable iff (rst)
               (redirect_valid && redirect_id == j) |-> !(stg_valid[k] && stg_mask[k][j]));
         end
      end
   endgenerate
endmodule

bind shp_cancel_pipe shp_cancel_pipe_chk #(
   .NUM_SH (NUM_SH),
   .DEPTH  (DEPTH),
   .DATA_W (DATA_W),
   .ID_W   (ID_W)
) u_chk (
   .clk            (clk),
   .rst            (rst),
   .iss_spec       (iss_spec),
   .iss_ready      (iss_ready),
   .resolve_valid  (resolve_valid),
   .resolve_id     (resolve_id),
   .cancel_valid   (cancel_valid),
   .cancel_id      (cancel_id),
   .redirect_valid (redirect_valid),
   .redirect_id    (redirect_id),
   .busy           (busy),
   .stg_valid      (stg_valid),
   .stg_mask       (stg_mask),
   .stg_data       (stg_data)
);

// File: tb/test_shp_cancel_pipe.sv
module test_shp_cancel_pipe;
   localparam int CLK_PERIOD = 10;
   localparam int NS    = 4;
   localparam int DEPTH = 6;
   localparam int DW    = 16;
   localparam int IW    = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          iss_valid = 1'b0, iss_spec = 1'b0;
   logic [DW-1:0] iss_a = '0, iss_b = '0;
   logic          iss_ready;
   logic [IW-1:0] iss_id;
   logic          resolve_valid = 1'b0, cancel_valid = 1'b0;
   logic [IW-1:0] resolve_id = '0, cancel_id = '0;
   logic          commit_valid, redirect_valid;
   logic [DW-1:0] commit_data;
   logic [IW-1:0] redirect_id;

   int total = 0, bad = 0, cyc_no = 0;
   bit done = 0;
   int clog[$];
   int ccyc[$];

   // reference model state
   int mv[DEPTH], md[DEPTH], mm[DEPTH];
   int mbusy = 0;
   bit mredir = 0;
   int mredid = 0;

   shp_cancel_pipe #(.NUM_SH(NS), .DEPTH(DEPTH), .DATA_W(DW)) i_shp_cancel_pipe (
      .clk(clk), .rst(rst),
      .iss_valid(iss_valid), .iss_spec(iss_spec), .iss_a(iss_a), .iss_b(iss_b),
      .iss_ready(iss_ready), .iss_id(iss_id),
      .resolve_valid(resolve_valid), .resolve_id(resolve_id),
      .cancel_valid(cancel_valid), .cancel_id(cancel_id),
      .commit_valid(commit_valid), .commit_data(commit_data),
      .redirect_valid(redirect_valid), .redirect_id(redirect_id)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic clear_in();
      iss_valid = 0; iss_spec = 0; iss_a = '0; iss_b = '0;
      resolve_valid = 0; cancel_valid = 0; resolve_id = '0; cancel_id = '0;
   endtask

   // one clock: compare DUT against the model, then advance both
   task automatic cyc();
      int cvec, rvec, aid, sum;
      bit ev[DEPTH];
      bit fr[DEPTH];
      bit cm, rdy, fire;
      #1;
      cvec = cancel_valid ? (1 << cancel_id) : 0;
      rvec = (resolve_valid && !(cancel_valid && cancel_id == resolve_id)) ? (1 << resolve_id) : 0;
      for (int i = 0; i < DEPTH; i++) ev[i] = mv[i] != 0 && (mm[i] & cvec) == 0;
      cm = ev[DEPTH-1] && mm[DEPTH-1] == 0;
      fr[DEPTH-1] = !ev[DEPTH-1] || cm;
      for (int i = DEPTH - 2; i >= 0; i--) fr[i] = !ev[i] || fr[i+1];
      aid = -1;
      for (int j = 0; j < NS; j++) if (aid < 0 && ((mbusy >> j) & 1) == 0) aid = j;
      rdy = !cancel_valid && fr[0] && (!iss_spec || aid >= 0);
      fire = iss_valid && rdy;
      sum = (int'(iss_a) + int'(iss_b)) & 16'hffff;
      if (!rst) begin
         chk(commit_valid == cm, "R1", "commit_valid", commit_valid, cm);
         if (cm) chk(int'(commit_data) == md[DEPTH-1], "R1", "commit_data", commit_data, md[DEPTH-1]);
         chk(iss_ready == rdy, "R3", "iss_ready", iss_ready, rdy);
         if (iss_spec && aid >= 0) chk(int'(iss_id) == aid, "R3", "iss_id", iss_id, aid);
         chk(redirect_valid == mredir, "R7", "redirect_valid", redirect_valid, mredir);
         if (mredir) chk(int'(redirect_id) == mredid, "R7", "redirect_id", redirect_id, mredid);
         if (commit_valid) begin clog.push_back(int'(commit_data)); ccyc.push_back(cyc_no); end
      end
      @(posedge clk);
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) begin mv[i] = 0; mm[i] = 0; md[i] = 0; end
         mbusy = 0; mredir = 0; mredid = 0;
      end else begin
         for (int i = DEPTH - 1; i >= 1; i--) begin
            if (fr[i]) begin
               if (ev[i-1]) begin mv[i] = 1; md[i] = md[i-1]; mm[i] = mm[i-1] & ~rvec; end
               else mv[i] = 0;
            end else mm[i] = mm[i] & ~rvec;
         end
         if (fr[0]) begin
            if (fire) begin
               mv[0] = 1; md[0] = sum;
               mm[0] = (mbusy & ~rvec) | (iss_spec ? (1 << aid) : 0);
            end else mv[0] = 0;
         end else mm[0] = mm[0] & ~rvec;
         mbusy = (mbusy & ~rvec & ~cvec) | ((fire && iss_spec) ? (1 << aid) : 0);
         mredir = cancel_valid;
         mredid = cancel_id;
      end
      cyc_no++;
      @(negedge clk);
   endtask

   task automatic idle(int n);
      clear_in();
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic do_reset();
      clear_in();
      rst = 1; cyc(); cyc();
      rst = 0;
      clog.delete(); ccyc.delete();
   endtask

   task automatic issue(bit spec, int a, int b);
      clear_in();
      iss_valid = 1; iss_spec = spec; iss_a = DW'(a); iss_b = DW'(b);
      cyc();
      clear_in();
   endtask

   initial begin
      int t0;
      @(negedge clk);
      do_reset();
      // R9: post-reset port state
      #1;
      chk(commit_valid == 0, "R9", "commit_valid after reset", commit_valid, 0);
      chk(iss_ready == 1, "R9", "iss_ready after reset", iss_ready, 1);
      chk(redirect_valid == 0, "R9", "redirect after reset", redirect_valid, 0);

      // R10 / R1: latency and sum
      t0 = cyc_no;
      issue(0, 3, 4);
      idle(DEPTH + 2);
      chk(clog.size() == 1, "R10", "commit count", clog.size(), 1);
      if (clog.size() == 1) begin
         chk(clog[0] == 7, "R1", "sum", clog[0], 7);
         chk(ccyc[0] - t0 == DEPTH, "R10", "latency", ccyc[0] - t0, DEPTH);
      end

      // R2 / R4 / R1: younger plain ops inherit the open shadow
      do_reset();
      iss_spec = 1; #1;
      chk(int'(iss_id) == 0, "R3", "first id", iss_id, 0);
      issue(1, 1, 1);
      issue(0, 2, 2);
      issue(0, 3, 3);
      idle(12);
      chk(clog.size() == 0, "R2", "held commits", clog.size(), 0);
      clear_in(); resolve_valid = 1; resolve_id = 0; cyc(); clear_in();
      idle(6);
      chk(clog.size() == 3, "R4", "released commits", clog.size(), 3);
      if (clog.size() == 3) begin
         chk(clog[0] == 2, "R1", "order 0", clog[0], 2);
         chk(clog[1] == 4, "R1", "order 1", clog[1], 4);
         chk(clog[2] == 6, "R1", "order 2", clog[2], 6);
      end
      iss_spec = 1; #1;
      chk(int'(iss_id) == 0, "R4", "id reuse", iss_id, 0);

      // R5 / R7: cancel the younger shadow
      do_reset();
      issue(1, 10, 0);
      issue(0, 11, 0);
      issue(1, 12, 0);
      issue(0, 13, 0);
      idle(8);
      clear_in(); cancel_valid = 1; cancel_id = 1; cyc(); clear_in();
      #1;
      chk(redirect_valid == 1, "R7", "redirect pulse", redirect_valid, 1);
      chk(int'(redirect_id) == 1, "R7", "redirect id", redirect_id, 1);
      idle(1);
      #1;
      chk(redirect_valid == 0, "R7", "redirect one cycle", redirect_valid, 0);
      clear_in(); resolve_valid = 1; resolve_id = 0; cyc(); clear_in();
      idle(8);
      chk(clog.size() == 2, "R5", "survivors", clog.size(), 2);
      if (clog.size() == 2) begin
         chk(clog[0] == 10, "R5", "survivor 0", clog[0], 10);
         chk(clog[1] == 11, "R5", "survivor 1", clog[1], 11);
      end

      // R6: cancel beats resolve on the same ID
      do_reset();
      issue(1, 5, 5);
      idle(8);
      clear_in(); cancel_valid = 1; cancel_id = 0; resolve_valid = 1; resolve_id = 0;
      cyc(); clear_in();
      idle(8);
      chk(clog.size() == 0, "R6", "dropped", clog.size(), 0);
      iss_spec = 1; #1;
      chk(int'(iss_id) == 0, "R6", "id freed", iss_id, 0);

      // R3: all IDs busy
      do_reset();
      for (int k = 0; k < NS; k++) begin
         iss_spec = 1; #1;
         chk(int'(iss_id) == k, "R3", "alloc order", iss_id, k);
         issue(1, k, 0);
      end
      iss_spec = 1; #1;
      chk(iss_ready == 0, "R3", "spec stall", iss_ready, 0);
      iss_spec = 0; #1;
      chk(iss_ready == 1, "R3", "plain still ready", iss_ready, 1);
      clear_in();

      // R8: cancel blocks issue
      do_reset();
      cancel_valid = 1; cancel_id = 2; iss_valid = 1; #1;
      chk(iss_ready == 0, "R8", "ready during cancel", iss_ready, 0);
      clear_in();

      // R9: reset mid-flight
      issue(1, 9, 9);
      idle(2);
      do_reset();
      idle(DEPTH + 2);
      chk(clog.size() == 0, "R9", "no commit after reset", clog.size(), 0);
      iss_spec = 1; #1;
      chk(int'(iss_id) == 0, "R9", "ids freed", iss_id, 0);
      clear_in();

      // random traffic against the model
      do_reset();
      for (int n = 0; n < 3000; n++) begin
         iss_valid     = ($urandom_range(0, 9) < 6);
         iss_spec      = ($urandom_range(0, 9) < 3);
         iss_a         = DW'($urandom);
         iss_b         = DW'($urandom);
         resolve_valid = ($urandom_range(0, 9) < 3);
         resolve_id    = IW'($urandom_range(0, NS - 1));
         cancel_valid  = ($urandom_range(0, 19) < 1);
         cancel_id     = IW'($urandom_range(0, NS - 1));
         cyc();
      end
      idle(4);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R1 watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule